// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control bits of a small microcontroller core. The ALU offers candidate flag values together with a per-flag mask. The block also takes single-cycle event strobes: interrupt entry, return from interrupt, and the commands that set or clear global interrupt enable. It keeps a transfer bit that a bit-store operation loads from any chosen bit of a supplied byte. A bit-load operation reads that transfer bit back out.

Software can overwrite the whole byte in one cycle, so an interrupt handler can save the register and restore it later. Hardware never does this on its own. An incoming interrupt request is passed on only while global interrupt enable is set.

The only data flowing in and out is the flag byte itself, and it moves on plain single-cycle strobes. There is no valid/ready pair and no back-pressure, because the register accepts every strobe in the cycle it is asserted. Updates become visible on the outputs one clock after the strobe.

Top module: `status_flag_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all eight bits of `flags_q` are 0, so interrupts are disabled.
- R2: The bit positions are: bit 7 global interrupt enable, bit 6 transfer, bit 5 half carry, bit 4 sign, bit 3 overflow, bit 2 negative, bit 1 zero, bit 0 carry. When `alu_upd` is high, each of bits 5, 3, 2, 1 and 0 whose `alu_mask` bit is 1 takes the matching `alu_flags` bit. Unmasked bits hold. Mask bits 7, 6 and 4 have no effect.
- R3: On an ALU update whose mask selects bit 2 or bit 3, the sign bit becomes the XOR of the negative and overflow bits being stored. Otherwise an ALU update leaves the sign bit unchanged.
- R4: `irq_fwd` is high exactly when `irq_pend` is high and bit 7 of `flags_q` is 1.
- R5: `irq_enter` clears bit 7 and `irq_return` sets bit 7.
- R6: `gie_set` sets bit 7 and `gie_clr` clears it. If both are high in the same cycle, the set wins.
- R7: Bit 7 follows this priority: `irq_enter`, then `irq_return`, then the set and clear commands.
- R8: `xfer_store` loads bit 6 from `xfer_src[xfer_sel]`. `xfer_bit` always shows bit 6.
- R9: `sw_wr` stores `sw_data` exactly as given, including the sign bit. It overrides every other event in the same cycle.
- R10: Interrupt entry and return change only bit 7. The other seven bits are not saved or restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Per-bit update mask |
| alu_flags | input | 8 | Candidate flag values at register positions |
| irq_enter | input | 1 | Interrupt taken strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| gie_set | input | 1 | Set interrupt enable command |
| gie_clr | input | 1 | Clear interrupt enable command |
| xfer_store | input | 1 | Bit-store strobe |
| xfer_src | input | 8 | Byte to pick the stored bit from |
| xfer_sel | input | 3 | Index of the bit to store |
| sw_wr | input | 1 | Full-byte software write strobe |
| sw_data | input | 8 | Byte for the software write |
| irq_pend | input | 1 | Interrupt request from the controller |
| flags_q | output | 8 | Current register value |
| gie | output | 1 | Global interrupt enable (bit 7) |
| xfer_bit | output | 1 | Transfer bit for a bit-load (bit 6) |
| irq_fwd | output | 1 | Gated interrupt request |

## Verification
The ALU path is exercised in four ways:
- an all-flags mask, which checks that every maskable bit lands in its own position;
- masks that touch only N or only V, which show the sign bit being recomputed from one new value and one held value;
- a mask that touches only carry, which shows the sign bit holding;
- a mask aimed only at bits 7, 6 and 4, which must change nothing.

Interrupt-enable strobes are applied alone and in conflicting pairs, so the result shows which source won. A software write is issued together with every other event, with a sign bit that disagrees with N XOR V, to show that the byte is stored exactly as written.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_Z  = 1;
  localparam int BIT_N  = 2;
  localparam int BIT_V  = 3;
  localparam int BIT_S  = 4;
  localparam int BIT_H  = 5;
  localparam int BIT_T  = 6;
  localparam int BIT_I  = 7;
  // Bits the ALU may write directly through its mask
  localparam logic [FLAG_W-1:0] ALU_MASKABLE =
    (FLAG_W'(1) << BIT_H) | (FLAG_W'(1) << BIT_V) | (FLAG_W'(1) << BIT_N) |
    (FLAG_W'(1) << BIT_Z) | (FLAG_W'(1) << BIT_C);
endpackage

// File: rtl/psr_alu_merge.sv
module psr_alu_merge
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic              upd,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] cand,
  output logic [FLAG_W-1:0] nxt
);
  logic sign_touch;
  logic unused_bits;

  assign sign_touch  = upd & (mask[BIT_N] | mask[BIT_V]);
  assign unused_bits = ^{mask[BIT_I], mask[BIT_T], mask[BIT_S],
                         cand[BIT_I], cand[BIT_T], cand[BIT_S]};

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (ALU_MASKABLE[b]) begin : g_direct
      assign nxt[b] = (upd & mask[b]) ? cand[b] : cur[b];
    end else if (b == BIT_S) begin : g_sign
      assign nxt[b] = sign_touch ? (nxt[BIT_N] ^ nxt[BIT_V]) : cur[b];
    end else begin : g_pass
      assign nxt[b] = cur[b];
    end
  end
endmodule

// File: rtl/psr_gie_ctrl.sv
module psr_gie_ctrl (
  input  logic cur,
  input  logic enter,
  input  logic ret,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic nxt
);
  always_comb begin
    if (enter)        nxt = 1'b0;
    else if (ret)     nxt = 1'b1;
    else if (set_cmd) nxt = 1'b1;
    else if (clr_cmd) nxt = 1'b0;
    else              nxt = cur;
  end
endmodule

// File: rtl/psr_xfer_bit.sv
module psr_xfer_bit #(
  parameter int SRC_W = 8,
  localparam int SEL_W = $clog2(SRC_W)
) (
  input  logic             cur,
  input  logic             store,
  input  logic [SRC_W-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             nxt
);
  assign nxt = store ? src[sel] : cur;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import psr_pkg::*;
#(
  parameter int SRC_W = 8,
  localparam int SEL_W = $clog2(SRC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              xfer_store,
  input  logic [SRC_W-1:0]  xfer_src,
  input  logic [SEL_W-1:0]  xfer_sel,
  input  logic              sw_wr,
  input  logic [FLAG_W-1:0] sw_data,
  input  logic              irq_pend,
  output logic [FLAG_W-1:0] flags_q,
  output logic              gie,
  output logic              xfer_bit,
  output logic              irq_fwd
);
  logic [FLAG_W-1:0] alu_nxt;
  logic              i_nxt;
  logic              t_nxt;
  logic [FLAG_W-1:0] flags_d;

  psr_alu_merge u_alu (
    .cur (flags_q),
    .upd (alu_upd),
    .mask(alu_mask),
    .cand(alu_flags),
    .nxt (alu_nxt)
  );

  psr_gie_ctrl u_gie (
    .cur    (flags_q[BIT_I]),
    .enter  (irq_enter),
    .ret    (irq_return),
    .set_cmd(gie_set),
    .clr_cmd(gie_clr),
    .nxt    (i_nxt)
  );

  psr_xfer_bit #(.SRC_W(SRC_W)) u_xfer (
    .cur  (flags_q[BIT_T]),
    .store(xfer_store),
    .src  (xfer_src),
    .sel  (xfer_sel),
    .nxt  (t_nxt)
  );

  always_comb begin
    flags_d        = alu_nxt;
    flags_d[BIT_I] = i_nxt;
    flags_d[BIT_T] = t_nxt;
    if (sw_wr) flags_d = sw_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign gie      = flags_q[BIT_I];
  assign xfer_bit = flags_q[BIT_T];
  assign irq_fwd  = irq_pend & flags_q[BIT_I];
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int SRC_W = 8,
  localparam int SEL_W = $clog2(SRC_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alu_upd,
  input logic [7:0]       alu_mask,
  input logic             irq_enter,
  input logic             irq_return,
  input logic             xfer_store,
  input logic [SRC_W-1:0] xfer_src,
  input logic [SEL_W-1:0] xfer_sel,
  input logic             sw_wr,
  input logic [7:0]       sw_data,
  input logic             irq_pend,
  input logic [7:0]       flags_q,
  input logic             gie,
  input logic             xfer_bit,
  input logic             irq_fwd
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> flags_q == 8'h00); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |-> (gie && irq_pend)); // R4
  AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !sw_wr) |=> !gie); // R5
  AST_RETURN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && !sw_wr) |=> gie); // R7
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && !sw_wr && (alu_mask[2] || alu_mask[3])) |=> flags_q[4] == (flags_q[3] ^ flags_q[2])); // R3
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_store && !sw_wr) |=> xfer_bit == $past(xfer_src[xfer_sel])); // R8
  AST_SW_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> flags_q == $past(sw_data)); // R9
  AST_NO_AUTOSAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !alu_upd && !xfer_store) |=> $stable(flags_q[6:0])); // R10
endmodule

bind status_flag_reg psr_checker #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alu_upd, irq_enter, irq_return, gie_set, gie_clr, xfer_store, sw_wr, irq_pend;
  logic [7:0] alu_mask, alu_flags, xfer_src, sw_data;
  logic [2:0] xfer_sel;
  logic [7:0] flags_q;
  logic       gie, xfer_bit, irq_fwd;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg i_status_flag_reg (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected next value, written from the requirements
  function automatic logic [7:0] predict(input logic [7:0] cur);
    logic [7:0] n = cur;
    if (sw_wr) return sw_data;                        // R9
    if (alu_upd) begin                                 // R2, R3
      foreach (n[b]) if (b inside {0, 1, 2, 3, 5} && alu_mask[b]) n[b] = alu_flags[b];
      if (alu_mask[2] || alu_mask[3]) n[4] = n[2] ^ n[3];
    end
    if (irq_enter)       n[7] = 1'b0;                  // R5, R7
    else if (irq_return) n[7] = 1'b1;
    else if (gie_set)    n[7] = 1'b1;                  // R6
    else if (gie_clr)    n[7] = 1'b0;
    if (xfer_store) n[6] = xfer_src[xfer_sel];         // R8
    return n;
  endfunction

  task automatic idle();
    {alu_upd, irq_enter, irq_return, gie_set, gie_clr, xfer_store, sw_wr, irq_pend} = '0;
    alu_mask = '0; alu_flags = '0; xfer_src = '0; sw_data = '0; xfer_sel = '0;
  endtask

  // Driver: inputs are already set; record the expectation and pass one edge
  task automatic push(input string req);
    logic [7:0] nxt;
    #1;
    check("R4 irq_fwd", {7'd0, irq_fwd}, {7'd0, irq_pend & model[7]});
    nxt = predict(model);
    exp_q.push_back(nxt);
    tag_q.push_back(req);
    model = nxt;
    @(negedge clk);
    idle();
  endtask

  // Monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, flags_q, e);
      check({t, " xfer_bit R8"}, {7'd0, xfer_bit}, {7'd0, e[6]});
      check({t, " gie"}, {7'd0, gie}, {7'd0, e[7]});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    sw_wr = 1'b1; sw_data = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", flags_q, 8'h00);
    idle();
    irq_pend = 1'b1;
    #1 check("R4 gated at reset", {7'd0, irq_fwd}, 8'h00);
    rst_n = 1'b1;
    push("R1 idle after reset");

    alu_upd = 1; alu_mask = 8'h2F; alu_flags = 8'hFF;           push("R2 all maskable");
    alu_upd = 1; alu_mask = 8'h04; alu_flags = 8'h00;           push("R3 N only");
    alu_upd = 1; alu_mask = 8'hD0; alu_flags = 8'hFF;           push("R2 mask 7,6,4 no effect");
    alu_upd = 1; alu_mask = 8'h01; alu_flags = 8'h00;           push("R3 sign holds");
    alu_upd = 1; alu_mask = 8'h08; alu_flags = 8'h00;           push("R3 V only");
    gie_set = 1; irq_pend = 1;                                  push("R6 set");
    irq_pend = 1;                                               push("R4 forward");
    gie_set = 1; gie_clr = 1;                                   push("R6 set wins");
    gie_clr = 1;                                                push("R6 clear");
    irq_return = 1;                                             push("R5 return");
    irq_enter = 1;                                              push("R5 R10 enter");
    irq_enter = 1; irq_return = 1;                              push("R7 enter beats return");
    irq_return = 1; gie_clr = 1;                                push("R7 return beats clear");
    irq_enter = 1; gie_set = 1;                                 push("R7 enter beats set");
    xfer_store = 1; xfer_src = 8'h20; xfer_sel = 3'd5;          push("R8 store one");
    xfer_store = 1; xfer_src = 8'hEF; xfer_sel = 3'd4;          push("R8 store zero");
    xfer_store = 1; xfer_src = 8'h80; xfer_sel = 3'd7;          push("R8 top index");
    sw_wr = 1; sw_data = 8'h50; irq_enter = 1; alu_upd = 1;
    alu_mask = 8'hFF; alu_flags = 8'h0F; xfer_store = 1;        push("R9 write beats all");
    sw_wr = 1; sw_data = 8'h91;                                 push("R9 exact byte");
    irq_return = 1;                                             push("R10 return keeps rest");

    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule